// File: doc/BRIEF.md
# Per-Slot Descriptor Chain Walker

This block follows the in-memory descriptor structure of one command-queue slot. The table is an array of slot entries. Each entry holds a task descriptor and, right after it, a link descriptor. The link descriptor points to a separate list of transfer descriptors. When `start` is pulsed with a slot number, the walker reads the slot's task descriptor and checks it. It then reads the link descriptor and walks the transfer list. For every transfer descriptor it emits one address/length pair, and it stops at the descriptor whose end flag is set.

Descriptor sizes depend on three configuration inputs, which are sampled when `start` is accepted:

- a large-task option, which makes the task descriptor 16 bytes instead of 8;
- 64-bit addressing, which makes link descriptors 16 bytes instead of 8 and transfer descriptors 16 bytes instead of 8;
- a short-transfer option, which in 64-bit mode shrinks the transfer stride to 12 bytes.

Memory is read one 32-bit word at a time through a simple request/response port, with one read outstanding at a time. The walk ends with a one-cycle `done`. When the walk was aborted, `err` is raised in that same cycle. Performing the data moves is the job of the consumer of the transfer pulses.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset `busy`, `rd_req`, `xfer_valid`, `done` and `err` are all low.
- R2: The first read of a walk is at `table_base + slot*(T+L)`. T is 16 when `cfg_wide_task` is set, else 8. L is 16 when `cfg_addr64` is set, else 8.
- R3: Word 0 of every descriptor is decoded as follows: bit 0 is valid, bit 1 is end, bits 5:3 are the action code, bits 31:16 are the length. A task descriptor must be valid with action 5; otherwise the walk ends with `done` and `err` and no transfer is emitted.
- R4: The link descriptor is read at slot entry + T. When it is valid with action 6 and end clear, the list address is taken from byte offset 4 (low word) and, in 64-bit mode, byte offset 8 (high word).
- R5: A link descriptor that is not valid but has end set marks the direct-command slot. The walk ends with `done`, no `err`, no transfer and no further reads. Any other invalid link descriptor, or one with a wrong action code, ends the walk with `err`.
- R6: Each transfer descriptor must be valid with action 4. It produces one `xfer_valid` pulse carrying the length from bits 31:16 and the address from byte offset 4 (plus byte offset 8 as the high word in 64-bit mode). The next descriptor lies 16 bytes on in 64-bit mode, 12 bytes on with `cfg_short_xfer`, and 8 bytes on in 32-bit mode.
- R7: A transfer descriptor with end set ends the walk. `done` is asserted with `err` low in the same cycle as that descriptor's `xfer_valid`.
- R8: A transfer descriptor that is not valid or has a wrong action code ends the walk with `done` and `err`, and emits nothing for that descriptor.
- R9: When MAX_XFER transfers have been emitted and none had end set, the walk ends with `err`, together with the last pulse.
- R10: `start` is ignored while `busy` is high.
- R11: In 32-bit mode the upper 32 address bits of every transfer are zero, and only one address word is read per link or transfer descriptor.
- R12: At most one read is outstanding. `rd_req` is a one-cycle pulse and is not raised again until the response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk for `slot` |
| slot | input | SLOT_W | Slot number to walk |
| table_base | input | 64 | Byte address of slot entry 0 |
| cfg_wide_task | input | 1 | Task descriptors are 16 bytes |
| cfg_addr64 | input | 1 | 64-bit addressing layout |
| cfg_short_xfer | input | 1 | 12-byte transfer stride in 64-bit mode |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | 64 | Byte address of the requested 32-bit word |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data |
| xfer_valid | output | 1 | One transfer request |
| xfer_addr | output | 64 | Transfer data address |
| xfer_len | output | 16 | Transfer data length |
| done | output | 1 | Walk finished (one cycle) |
| err | output | 1 | Walk aborted, valid with `done` |
| busy | output | 1 | A walk is in progress |

## Verification
The bench walks slots in all three stride layouts and checks the first two read addresses. A design that computed the slot stride or the link offset wrongly would read the wrong entry and emit nothing or garbage. It runs the direct-command slot, where a walker that treated an invalid link as an error, or followed it anyway, would raise `err` or issue extra reads. Lists are cut by an invalid descriptor, run exactly MAX_XFER long with and without an end flag, and entered with a second `start` mid-walk. Each of these exposes an off-by-one bound, emission of a bad descriptor, or a restart that corrupts the running walk.

// File: rtl/desc_chain_walker.sv
module desc_chain_walker #(
  parameter int SLOT_W   = 5,
  parameter int MAX_XFER = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOT_W-1:0] slot,
  input  logic [63:0]       table_base,
  input  logic              cfg_wide_task,
  input  logic              cfg_addr64,
  input  logic              cfg_short_xfer,
  output logic              rd_req,
  output logic [63:0]       rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              xfer_valid,
  output logic [63:0]       xfer_addr,
  output logic [15:0]       xfer_len,
  output logic              done,
  output logic              err,
  output logic              busy
);
  localparam int CNT_W = $clog2(MAX_XFER + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_XFER - 1);
  localparam logic [2:0] ACT_TASK = 3'd5;
  localparam logic [2:0] ACT_XFER = 3'd4;
  localparam logic [2:0] ACT_LINK = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE, S_TASK, S_LINK0, S_LINK_LO, S_LINK_HI, S_XF0, S_XF_LO, S_XF_HI
  } state_t;

  state_t           state;
  logic             pend, wide_q, a64_q, short_q, end_q;
  logic [63:0]      ptr;
  logic [31:0]      lo_q;
  logic [15:0]      len_q;
  logic [CNT_W-1:0] cnt;

  logic        rsp, d_vld, d_end, emit;
  logic [2:0]  d_act;
  logic [63:0] task_len, xstride, slot_stride, offset, emit_addr;
  logic        unused_bits;

  assign rsp         = rd_rsp_valid && pend;
  assign d_vld       = rd_rsp_data[0];
  assign d_end       = rd_rsp_data[1];
  assign d_act       = rd_rsp_data[5:3];
  assign unused_bits = ^{rd_rsp_data[15:6], rd_rsp_data[2]};

  assign task_len    = wide_q ? 64'd16 : 64'd8;
  assign xstride     = !a64_q ? 64'd8 : (short_q ? 64'd12 : 64'd16);
  assign slot_stride = (cfg_wide_task ? 64'd16 : 64'd8) + (cfg_addr64 ? 64'd16 : 64'd8);

  always_comb begin
    case (state)
      S_LINK_LO, S_XF_LO: offset = 64'd4;
      S_LINK_HI, S_XF_HI: offset = 64'd8;
      default:            offset = 64'd0;
    endcase
  end

  assign busy      = (state != S_IDLE);
  assign rd_req    = busy && !pend;
  assign rd_addr   = ptr + offset;
  assign emit      = rsp && (state == S_XF_HI || (state == S_XF_LO && !a64_q));
  assign emit_addr = (state == S_XF_HI) ? {rd_rsp_data, lo_q} : {32'd0, rd_rsp_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  pend <= 1'b0;
      wide_q <= 1'b0;   a64_q <= 1'b0;  short_q <= 1'b0;  end_q <= 1'b0;
      ptr <= '0;  lo_q <= '0;  len_q <= '0;  cnt <= '0;
      xfer_valid <= 1'b0;  xfer_addr <= '0;  xfer_len <= '0;
      done <= 1'b0;  err <= 1'b0;
    end else begin
      done <= 1'b0;  err <= 1'b0;  xfer_valid <= 1'b0;
      if (rd_req) pend <= 1'b1;
      else if (rsp) pend <= 1'b0;

      if (state == S_IDLE) begin
        if (start) begin
          wide_q  <= cfg_wide_task;
          a64_q   <= cfg_addr64;
          short_q <= cfg_short_xfer;
          ptr     <= table_base + 64'(slot) * slot_stride;
          cnt     <= '0;
          state   <= S_TASK;
        end
      end else if (emit) begin
        xfer_valid <= 1'b1;
        xfer_addr  <= emit_addr;
        xfer_len   <= len_q;
        if (end_q) begin
          state <= S_IDLE;  done <= 1'b1;
        end else if (cnt == LAST) begin
          state <= S_IDLE;  done <= 1'b1;  err <= 1'b1;
        end else begin
          cnt   <= cnt + 1'b1;
          ptr   <= ptr + xstride;
          state <= S_XF0;
        end
      end else if (rsp) begin
        case (state)
          S_TASK:
            if (d_vld && d_act == ACT_TASK) begin
              ptr <= ptr + task_len;  state <= S_LINK0;
            end else begin
              state <= S_IDLE;  done <= 1'b1;  err <= 1'b1;
            end
          S_LINK0:
            if (d_vld && d_act == ACT_LINK && !d_end) state <= S_LINK_LO;
            else begin
              state <= S_IDLE;  done <= 1'b1;  err <= d_vld || !d_end;
            end
          S_LINK_LO: begin
            lo_q <= rd_rsp_data;
            if (a64_q) state <= S_LINK_HI;
            else begin
              ptr <= {32'd0, rd_rsp_data};  state <= S_XF0;
            end
          end
          S_LINK_HI: begin
            ptr <= {rd_rsp_data, lo_q};  state <= S_XF0;
          end
          S_XF0:
            if (d_vld && d_act == ACT_XFER) begin
              len_q <= rd_rsp_data[31:16];  end_q <= d_end;  state <= S_XF_LO;
            end else begin
              state <= S_IDLE;  done <= 1'b1;  err <= 1'b1;
            end
          S_XF_LO: begin
            lo_q <= rd_rsp_data;  state <= S_XF_HI;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !busy && !done && !xfer_valid);
  assert_single_request_R12: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req);
  assert_response_expected_R12: assert property (@(posedge clk) disable iff (!rst_n) rd_rsp_valid |-> pend);
  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n) err |-> done);
  assert_done_returns_idle_R7: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST);
  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !a64_q |-> xfer_addr[63:32] == 32'd0);
endmodule

// File: tb/desc_chain_walker_bench.sv
`timescale 1ns/1ps
module desc_chain_walker_bench;
  localparam int MAXX = 8;
  localparam logic [63:0] BASE = 64'h100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [4:0] slot = '0;
  logic wide = 1'b0, a64 = 1'b1, shrt = 1'b0;
  logic rd_req, rd_rsp_valid, xfer_valid, done, err, busy;
  logic [63:0] rd_addr, xfer_addr;
  logic [31:0] rd_rsp_data;
  logic [15:0] xfer_len;

  always #4 clk = ~clk;

  desc_chain_walker #(.SLOT_W(5), .MAX_XFER(MAXX)) u_desc_chain_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .slot(slot), .table_base(BASE),
    .cfg_wide_task(wide), .cfg_addr64(a64), .cfg_short_xfer(shrt),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .done(done), .err(err), .busy(busy));

  logic [31:0] mem [0:1023];
  logic p1v;
  logic [63:0] p1a;
  always @(posedge clk) begin
    if (!rst_n) begin
      p1v <= 1'b0; rd_rsp_valid <= 1'b0;
    end else begin
      p1v <= rd_req; p1a <= rd_addr;
      rd_rsp_valid <= p1v; rd_rsp_data <= mem[p1a[11:2]];
    end
  end

  int checks = 0, fails = 0;
  int n_rd, n_x, outst, overlap;
  bit got_done, got_err;
  logic [63:0] rd_log [0:63];
  logic [63:0] x_addr [0:31];
  logic [15:0] x_len  [0:31];
  logic [63:0] e_addr [0:31];
  logic [15:0] e_len  [0:31];

  always @(negedge clk) begin
    if (rd_req) begin
      if (outst != 0) overlap++;
      if (n_rd < 64) rd_log[n_rd] = rd_addr;
      n_rd++; outst = 1;
    end
    if (rd_rsp_valid) outst = 0;
    if (xfer_valid) begin
      if (n_x < 32) begin x_addr[n_x] = xfer_addr; x_len[n_x] = xfer_len; end
      n_x++;
    end
    if (done) begin got_done = 1; got_err = err; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [63:0] a, input logic [31:0] d);
    mem[a[11:2]] = d;
  endtask

  function automatic logic [31:0] w0(input bit v, input bit e, input logic [2:0] act, input logic [15:0] len);
    return {len, 10'd0, act, 1'b0, e, v};
  endfunction

  function automatic logic [63:0] sbase(input int s);
    return BASE + 64'(s) * ((wide ? 64'd16 : 64'd8) + (a64 ? 64'd16 : 64'd8));
  endfunction

  function automatic logic [63:0] xstep();
    return !a64 ? 64'd8 : (shrt ? 64'd12 : 64'd16);
  endfunction

  task automatic setup_slot(input int s, input logic [31:0] link0, input logic [63:0] list);
    logic [63:0] sb = sbase(s);
    wr(sb, w0(1, 1, 3'd5, 16'd4));
    wr(sb + (wide ? 64'd16 : 64'd8), link0);
    wr(sb + (wide ? 64'd16 : 64'd8) + 4, list[31:0]);
    if (a64) wr(sb + (wide ? 64'd16 : 64'd8) + 8, list[63:32]);
  endtask

  task automatic put_list(input logic [63:0] list, input int n, input int end_at, input int bad_at);
    for (int i = 0; i < n; i++) begin
      logic [63:0] p = list + 64'(i) * xstep();
      e_len[i]  = 16'h200 + 16'(i * 16'h40);
      e_addr[i] = a64 ? {32'h0000_0010 + 32'(i), 32'hA000_0000 + 32'(i * 32'h100)}
                      : {32'd0, 32'hB000_0000 + 32'(i * 32'h100)};
      wr(p, w0(i != bad_at, i == end_at, 3'd4, e_len[i]));
      wr(p + 4, e_addr[i][31:0]);
      if (a64) wr(p + 8, e_addr[i][63:32]);
    end
  endtask

  task automatic clear_mon();
    n_rd = 0; n_x = 0; got_done = 0; got_err = 0; overlap = 0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!got_done && t < 3000) begin @(negedge clk); t++; end
    chk(got_done, req, "walk finished", 64'(got_done), 64'd1);
  endtask

  task automatic walk(input int s, input string req);
    clear_mon();
    @(negedge clk); slot = 5'(s); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(req);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_xfers(input string req, input int exp_n, input bit exp_err);
    chk(n_x == exp_n, req, "transfer count", 64'(n_x), 64'(exp_n));
    chk(got_err == exp_err, req, "err flag", 64'(got_err), 64'(exp_err));
    for (int i = 0; i < exp_n && i < n_x; i++) begin
      chk(x_addr[i] == e_addr[i], req, "transfer address", x_addr[i], e_addr[i]);
      chk(x_len[i] == e_len[i], req, "transfer length", 64'(x_len[i]), 64'(e_len[i]));
    end
  endtask

  task automatic t_reset();
    chk(!busy && !rd_req && !xfer_valid && !done && !err, "R1", "outputs after reset",
        {59'd0, busy, rd_req, xfer_valid, done, err}, 64'd0);
  endtask

  task automatic t_wide64();
    wide = 0; a64 = 1; shrt = 0;
    setup_slot(3, w0(1, 0, 3'd6, 0), 64'h800);
    put_list(64'h800, 3, 2, -1);
    walk(3, "R6");
    chk(rd_log[0] == 64'h148, "R2", "task read address", rd_log[0], 64'h148);
    chk(rd_log[1] == 64'h150, "R4", "link read address", rd_log[1], 64'h150);
    check_xfers("R6", 3, 0);
    chk(n_rd == 13, "R7", "reads for three descriptors", 64'(n_rd), 64'd13);
    chk(overlap == 0, "R12", "overlapping reads", 64'(overlap), 64'd0);
  endtask

  task automatic t_short();
    wide = 1; a64 = 1; shrt = 1;
    setup_slot(5, w0(1, 0, 3'd6, 0), 64'h900);
    put_list(64'h900, 2, 1, -1);
    walk(5, "R6");
    chk(rd_log[0] == 64'h1A0, "R2", "wide task slot address", rd_log[0], 64'h1A0);
    chk(rd_log[1] == 64'h1B0, "R4", "link after wide task", rd_log[1], 64'h1B0);
    check_xfers("R6", 2, 0);
  endtask

  task automatic t_addr32();
    wide = 1; a64 = 0; shrt = 1;
    setup_slot(2, w0(1, 0, 3'd6, 0), 64'hA00);
    put_list(64'hA00, 2, 1, -1);
    walk(2, "R11");
    chk(rd_log[0] == 64'h130, "R2", "32-bit slot address", rd_log[0], 64'h130);
    check_xfers("R11", 2, 0);
    chk(n_rd == 7, "R11", "single address word reads", 64'(n_rd), 64'd7);
  endtask

  task automatic t_dcmd();
    wide = 0; a64 = 1; shrt = 0;
    setup_slot(31, w0(0, 1, 3'd0, 0), 64'h0);
    walk(31, "R5");
    check_xfers("R5", 0, 0);
    chk(n_rd == 2, "R5", "reads for command slot", 64'(n_rd), 64'd2);
  endtask

  task automatic t_bad_task();
    wide = 0; a64 = 1; shrt = 0;
    setup_slot(1, w0(1, 0, 3'd6, 0), 64'h800);
    wr(sbase(1), w0(1, 1, 3'd4, 16'd1));
    walk(1, "R3");
    check_xfers("R3", 0, 1);
    chk(n_rd == 1, "R3", "reads after bad task", 64'(n_rd), 64'd1);
  endtask

  task automatic t_bad_link();
    wide = 0; a64 = 1; shrt = 0;
    setup_slot(10, w0(1, 0, 3'd5, 0), 64'h800);
    walk(10, "R5");
    check_xfers("R5", 0, 1);
  endtask

  task automatic t_bad_xfer();
    wide = 0; a64 = 1; shrt = 0;
    setup_slot(12, w0(1, 0, 3'd6, 0), 64'hB00);
    put_list(64'hB00, 3, 2, 1);
    walk(12, "R8");
    check_xfers("R8", 1, 1);
  endtask

  task automatic t_limit();
    wide = 0; a64 = 1; shrt = 0;
    setup_slot(14, w0(1, 0, 3'd6, 0), 64'hC00);
    put_list(64'hC00, MAXX + 1, -1, -1);
    walk(14, "R9");
    check_xfers("R9", MAXX, 1);
    setup_slot(16, w0(1, 0, 3'd6, 0), 64'hD00);
    put_list(64'hD00, MAXX, MAXX - 1, -1);
    walk(16, "R9");
    check_xfers("R9", MAXX, 0);
  endtask

  task automatic t_restart();
    wide = 0; a64 = 1; shrt = 0;
    setup_slot(3, w0(1, 0, 3'd6, 0), 64'h800);
    put_list(64'h800, 3, 2, -1);
    clear_mon();
    @(negedge clk); slot = 5'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    slot = 5'd20; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done("R10");
    repeat (3) @(negedge clk);
    chk(rd_log[0] == 64'h148, "R10", "walk kept original slot", rd_log[0], 64'h148);
    check_xfers("R10", 3, 0);
    chk(n_rd == 13, "R10", "no restart reads", 64'(n_rd), 64'd13);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    outst = 0;
    clear_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_wide64();
    t_short();
    t_addr32();
    t_dcmd();
    t_bad_task();
    t_bad_link();
    t_bad_xfer();
    t_limit();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule